// File: doc/BRIEF.md
# Packed Unsigned Dot-Product Accumulator

This block is a vector datapath. Each 32-bit lane takes two unsigned 16-bit values from each of two source vectors. It multiplies the low halves together and the high halves together, then adds both 32-bit products to the lane's accumulator value. The sum wraps modulo 2^32, with no saturation. The vector width `VLEN` is a parameter. It must be a nonzero multiple of 32, and an elaboration-time check rejects any other value. Every lane is computed and written on every operation, and there is no per-lane enable.

A small decoder sits beside the datapath. It checks the fixed bits of the 32-bit operation word and exposes the three 5-bit register indices straight away, so that a surrounding register file can fetch the operands. The accumulator vector is both a source and the destination: the result leaves with the accumulator index so that it can be written back over the old value.

Operations arrive on a valid/ready input stream and leave on a valid/ready output stream through a single output register. The input is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output data and index are held unchanged and no new input is accepted. A word with a bad fixed bit is consumed by the handshake but produces no result.

Top module: `pdot_accum`

## Requirements
- R1: For every lane e, the operands are bits [32e+31:32e] of `in_src_a`, `in_src_b` and `in_acc`, and the result goes to the same bits of `out_result`. The low 16 bits of the A lane are multiplied by the low 16 bits of the B lane, and the high 16 bits by the high 16 bits. The lane result is the accumulator lane plus both products.
- R2: Both 16-bit operands are unsigned and each product is formed at 32 bits, so 0xFFFF times 0xFFFF contributes 0xFFFE0001 and is never sign-extended.
- R3: The lane sum is truncated to 32 bits, so overflow wraps. For example, all-ones sources with an accumulator of 0xFFFFFFFF give 0xFFFC0001.
- R4: Every lane is computed and written on every accepted operation, whatever its values, including lanes whose result equals their accumulator.
- R5: An operation word is legal only when bits [31:21] equal 01000100000 and bits [15:10] equal 110011. `insn_illegal` is a combinational output that is high exactly when `in_valid` is high and the word is not legal.
- R6: `dec_srcb_idx` = `in_insn`[20:16], `dec_srca_idx` = `in_insn`[9:5] and `dec_acc_idx` = `in_insn`[4:0], all combinational. `out_dst_idx` carries the accumulator index of the operation whose result is on `out_result`.
- R7: An illegal word that is accepted by the handshake issues no operation: `out_valid` is low on the following cycle.
- R8: After a legal word is accepted at a clock edge, `out_valid` is high and the result is on `out_result` from that same edge on. Back-to-back operations can complete one per cycle while `out_ready` stays high.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While that holds, `out_valid`, `out_result` and `out_dst_idx` stay stable.
- R10: Synchronous active-high `rst` clears `out_valid` at the next clock edge. The data registers are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation is present |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_insn | input | 32 | Operation word to decode |
| in_src_a | input | VLEN | First source vector |
| in_src_b | input | VLEN | Second source vector |
| in_acc | input | VLEN | Accumulator vector (third source) |
| dec_srca_idx | output | 5 | First-source register index |
| dec_srcb_idx | output | 5 | Second-source register index |
| dec_acc_idx | output | 5 | Accumulator/destination register index |
| insn_illegal | output | 1 | Presented word has a bad fixed bit |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | VLEN | Accumulated result vector |
| out_dst_idx | output | 5 | Destination index for the result |

## Verification
The decoder outputs and `insn_illegal` are combinational, so the bench checks them in the same cycle the word is driven, shortly after it changes the inputs on the falling edge. The result register loads at the first rising edge after acceptance, so the result, `out_valid` and the destination index are sampled at the next falling edge. Hold behaviour and `in_ready` are checked on each following falling edge of a stall. The drain is checked one edge after `out_ready` rises, and the reset clear one edge after `rst` rises.

// File: rtl/pdot_pkg.sv
package pdot_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned HALF_W = LANE_W / 2;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned WORD_W = 32;

  // fixed-bit fields of the operation word
  localparam int unsigned HI_LSB  = 21;
  localparam int unsigned HI_W    = WORD_W - HI_LSB;
  localparam int unsigned MID_LSB = 10;
  localparam int unsigned MID_W   = 6;
  localparam logic [HI_W-1:0]  HI_CODE  = 11'b01000100000;
  localparam logic [MID_W-1:0] MID_CODE = 6'b110011;

  // register index fields
  localparam int unsigned SRCB_LSB = 16;
  localparam int unsigned SRCA_LSB = 5;
  localparam int unsigned ACC_LSB  = 0;

  typedef logic [IDX_W-1:0] reg_idx_t;

  typedef struct packed {
    reg_idx_t srcb;
    reg_idx_t srca;
    reg_idx_t acc;
  } idx_set_t;
endpackage

// File: rtl/pdot_decode.sv
module pdot_decode
  import pdot_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              legal,
  output idx_set_t          idx
);
  logic hi_ok;
  logic mid_ok;

  always_comb begin
    hi_ok    = (word[HI_LSB +: HI_W] == HI_CODE);
    mid_ok   = (word[MID_LSB +: MID_W] == MID_CODE);
    legal    = hi_ok && mid_ok;
    idx.srcb = word[SRCB_LSB +: IDX_W];
    idx.srca = word[SRCA_LSB +: IDX_W];
    idx.acc  = word[ACC_LSB +: IDX_W];
  end
endmodule

// File: rtl/pdot_lane.sv
module pdot_lane #(
  parameter int unsigned LW = 32
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic [LW-1:0] acc,
  output logic [LW-1:0] sum
);
  localparam int unsigned HW    = LW / 2;
  localparam int unsigned PARTS = 2;

  logic [LW-1:0] prod [PARTS];

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    logic [LW-1:0] a_w;
    logic [LW-1:0] b_w;
    always_comb begin
      a_w     = {{(LW-HW){1'b0}}, a[p*HW +: HW]};
      b_w     = {{(LW-HW){1'b0}}, b[p*HW +: HW]};
      prod[p] = a_w * b_w;
    end
  end

  always_comb begin
    sum = acc;
    for (int p = 0; p < PARTS; p++) begin
      sum = sum + prod[p];
    end
  end
endmodule

// File: rtl/pdot_outstage.sv
module pdot_outstage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          can_take,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [DW-1:0] q_data
);
  always_comb can_take = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
    end else if (q_ready) begin
      q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_data <= load_data;
    end
  end
endmodule

// File: rtl/pdot_accum.sv
module pdot_accum
  import pdot_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_insn,
  input  logic [VLEN-1:0]   in_src_a,
  input  logic [VLEN-1:0]   in_src_b,
  input  logic [VLEN-1:0]   in_acc,
  output logic [IDX_W-1:0]  dec_srca_idx,
  output logic [IDX_W-1:0]  dec_srcb_idx,
  output logic [IDX_W-1:0]  dec_acc_idx,
  output logic              insn_illegal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VLEN-1:0]   out_result,
  output logic [IDX_W-1:0]  out_dst_idx
);
  localparam int unsigned LANES = VLEN / LANE_W;
  localparam int unsigned PAY_W = VLEN + IDX_W;

  if (VLEN == 0 || (VLEN % LANE_W) != 0) begin : g_bad_vlen
    $error("VLEN must be a nonzero multiple of the lane width");
  end

  logic              word_ok;
  idx_set_t          idx;
  logic [VLEN-1:0]   lane_sum;
  logic              issue;
  logic [PAY_W-1:0]  pay_d;
  logic [PAY_W-1:0]  pay_q;

  pdot_decode u_dec (
    .word  (in_insn),
    .legal (word_ok),
    .idx   (idx)
  );

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    pdot_lane #(.LW(LANE_W)) u_lane (
      .a   (in_src_a[e*LANE_W +: LANE_W]),
      .b   (in_src_b[e*LANE_W +: LANE_W]),
      .acc (in_acc[e*LANE_W +: LANE_W]),
      .sum (lane_sum[e*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    dec_srca_idx = idx.srca;
    dec_srcb_idx = idx.srcb;
    dec_acc_idx  = idx.acc;
    insn_illegal = in_valid && !word_ok;
    issue        = in_valid && in_ready && word_ok;
    pay_d        = {idx.acc, lane_sum};
  end

  pdot_outstage #(.DW(PAY_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (issue),
    .load_data (pay_d),
    .can_take  (in_ready),
    .q_valid   (out_valid),
    .q_ready   (out_ready),
    .q_data    (pay_q)
  );

  always_comb begin
    out_result  = pay_q[VLEN-1:0];
    out_dst_idx = pay_q[PAY_W-1 -: IDX_W];
  end
endmodule

// File: rtl/pdot_accum_chk.sv
module pdot_accum_chk
  import pdot_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_insn,
  input logic [VLEN-1:0]   in_src_a,
  input logic [VLEN-1:0]   in_src_b,
  input logic [VLEN-1:0]   in_acc,
  input logic              insn_illegal,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VLEN-1:0]   out_result,
  input logic [IDX_W-1:0]  out_dst_idx
);
  // R10: reset empties the output register
  p_reset_clears_r10: assert property (@(posedge clk) rst |=> !out_valid);

  // R9: a stalled output blocks the input
  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: a stalled output holds its contents
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_dst_idx)));

  // R7: a consumed bad word issues nothing
  p_illegal_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && insn_illegal) |=> !out_valid);

  // R8: a consumed legal word yields a result on the next cycle
  p_issue_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !insn_illegal) |=> out_valid);

  // R6: destination index follows the word
  p_dst_idx_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !insn_illegal) |=> (out_dst_idx == $past(in_insn[4:0])));

  // R1: lane 0 dot-product accumulate
  p_lane0_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !insn_illegal) |=>
      (out_result[31:0] == $past(in_acc[31:0]
        + 32'(in_src_a[15:0]) * 32'(in_src_b[15:0])
        + 32'(in_src_a[31:16]) * 32'(in_src_b[31:16]))));
endmodule

bind pdot_accum pdot_accum_chk #(.VLEN(VLEN)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_insn      (in_insn),
  .in_src_a     (in_src_a),
  .in_src_b     (in_src_b),
  .in_acc       (in_acc),
  .insn_illegal (insn_illegal),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_dst_idx  (out_dst_idx)
);

// File: tb/pdot_accum_tb.sv
module pdot_accum_tb_top;
  localparam int unsigned VLEN  = 128;
  localparam int unsigned LANES = VLEN / 32;
  localparam logic [31:0] BASE_WORD = 32'h4400_CC00;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     in_insn = '0;
  logic [VLEN-1:0] in_src_a = '0;
  logic [VLEN-1:0] in_src_b = '0;
  logic [VLEN-1:0] in_acc = '0;
  logic [4:0]      dec_srca_idx, dec_srcb_idx, dec_acc_idx;
  logic            insn_illegal;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [VLEN-1:0] out_result;
  logic [4:0]      out_dst_idx;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pdot_accum #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_acc(in_acc),
    .dec_srca_idx(dec_srca_idx), .dec_srcb_idx(dec_srcb_idx), .dec_acc_idx(dec_acc_idx),
    .insn_illegal(insn_illegal), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_dst_idx(out_dst_idx)
  );

  function automatic logic [31:0] lane_ref(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] p_lo, p_hi;
    p_lo = {16'h0, a[15:0]} * {16'h0, b[15:0]};
    p_hi = {16'h0, a[31:16]} * {16'h0, b[31:16]};
    return c + p_lo + p_hi;
  endfunction

  function automatic logic [VLEN-1:0] vec_ref(logic [VLEN-1:0] a, logic [VLEN-1:0] b,
                                              logic [VLEN-1:0] c);
    logic [VLEN-1:0] r;
    for (int e = 0; e < LANES; e++) r[e*32 +: 32] = lane_ref(a[e*32 +: 32], b[e*32 +: 32], c[e*32 +: 32]);
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int e = 0; e < LANES; e++) v[e*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] mk_word(logic [4:0] m, logic [4:0] n, logic [4:0] d);
    return BASE_WORD | (32'(m) << 16) | (32'(n) << 5) | 32'(d);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    for (int e = 0; e < LANES; e++) chk(tag, act[e*32 +: 32], exp[e*32 +: 32]);
  endtask

  // one operation with a stall of 'stall' cycles before the consumer drains it
  task automatic run_op(logic [31:0] w, logic [VLEN-1:0] a, logic [VLEN-1:0] b,
                        logic [VLEN-1:0] c, bit legal, int stall, string tag);
    logic [VLEN-1:0] exp_v;
    logic [VLEN-1:0] held;
    exp_v = vec_ref(a, b, c);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_src_a = a; in_src_b = b; in_acc = c; out_ready = 1'b0;
    #1;
    chk({tag, " R5 illegal flag"}, 32'(insn_illegal), 32'(!legal));
    chk("R6 srcb idx", 32'(dec_srcb_idx), 32'(w[20:16]));
    chk("R6 srca idx", 32'(dec_srca_idx), 32'(w[9:5]));
    chk("R6 acc idx", 32'(dec_acc_idx), 32'(w[4:0]));
    chk("R9 ready when empty", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    if (!legal) begin
      chk({tag, " R7 no issue"}, 32'(out_valid), 32'd0);
    end else begin
      chk({tag, " R8 valid"}, 32'(out_valid), 32'd1);
      chk_vec({tag, " R1 result"}, out_result, exp_v);
      chk({tag, " R6 dst idx"}, 32'(out_dst_idx), 32'(w[4:0]));
      held = out_result;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R9 hold valid", 32'(out_valid), 32'd1);
        chk("R9 not ready", 32'(in_ready), 32'd0);
        chk_vec("R9 hold data", out_result, held);
      end
      out_ready = 1'b1;
      #1;
      chk("R9 ready on drain", 32'(in_ready), 32'd1);
      @(negedge clk);
      chk("R9 drained", 32'(out_valid), 32'd0);
      out_ready = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] a, b, c, a2, b2, c2;
    logic [31:0] w, w2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", 32'(out_valid), 32'd0);
    rst = 1'b0;

    // R1/R4 distinct lane values, low and high halves different
    for (int e = 0; e < LANES; e++) begin
      a[e*32 +: 32] = {16'(3 + e), 16'(1 + e)};
      b[e*32 +: 32] = {16'(4 + e), 16'(2 + e)};
      c[e*32 +: 32] = 32'(100 * e);
    end
    run_op(mk_word(5'd3, 5'd7, 5'd11), a, b, c, 1'b1, 2, "R1 R4 directed");

    // R2 unsigned widening, R3 wrap
    a = '1; b = '1; c = '0;
    run_op(mk_word(5'd31, 5'd0, 5'd31), a, b, c, 1'b1, 0, "R2 all-ones");
    c = '1;
    run_op(mk_word(5'd0, 5'd31, 5'd0), a, b, c, 1'b1, 1, "R3 wrap");
    chk("R3 wrap constant", lane_ref(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF), 32'hFFFC_0001);

    // R4 zero products leave accumulator unchanged but still written
    a = '0; b = rnd_vec(); c = rnd_vec();
    run_op(mk_word(5'd1, 5'd2, 5'd4), a, b, c, 1'b1, 0, "R4 zero src");

    // R5 R7 single flipped fixed bits
    run_op(mk_word(5'd1, 5'd2, 5'd3) ^ 32'h8000_0000, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 0, "R5 bit31");
    run_op(mk_word(5'd1, 5'd2, 5'd3) ^ 32'h0020_0000, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 0, "R5 bit21");
    run_op(mk_word(5'd1, 5'd2, 5'd3) ^ 32'h0000_0400, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 0, "R5 bit10");

    // R8 back-to-back with consumer always ready
    a = rnd_vec(); b = rnd_vec(); c = rnd_vec(); w = mk_word(5'd9, 5'd10, 5'd12);
    a2 = rnd_vec(); b2 = rnd_vec(); c2 = rnd_vec(); w2 = mk_word(5'd13, 5'd14, 5'd15);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_insn = w; in_src_a = a; in_src_b = b; in_acc = c;
    @(negedge clk);
    chk("R8 b2b first valid", 32'(out_valid), 32'd1);
    chk_vec("R8 b2b first data", out_result, vec_ref(a, b, c));
    chk("R8 b2b ready", 32'(in_ready), 32'd1);
    in_insn = w2; in_src_a = a2; in_src_b = b2; in_acc = c2;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 b2b second valid", 32'(out_valid), 32'd1);
    chk_vec("R8 b2b second data", out_result, vec_ref(a2, b2, c2));
    chk("R6 b2b second dst", 32'(out_dst_idx), 32'd15);
    @(negedge clk);
    chk("R8 b2b drained", 32'(out_valid), 32'd0);
    out_ready = 1'b0;

    // R10 reset while a result is held
    @(negedge clk);
    in_valid = 1'b1; in_insn = mk_word(5'd2, 5'd2, 5'd2); in_src_a = rnd_vec();
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 pre-reset valid", 32'(out_valid), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears valid", 32'(out_valid), 32'd0);
    rst = 1'b0;

    // random mix
    for (int i = 0; i < 60; i++) begin
      bit lg;
      logic [31:0] rw;
      lg = ($urandom % 5) != 0;
      rw = mk_word(5'($urandom), 5'($urandom), 5'($urandom));
      if (!lg) begin
        int pos;
        pos = ($urandom % 2 == 0) ? int'(21 + $urandom % 11) : int'(10 + $urandom % 6);
        rw[pos] = ~rw[pos];
      end
      run_op(rw, rnd_vec(), rnd_vec(), rnd_vec(), lg, int'($urandom % 3), "R1 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule